// File: doc/BRIEF.md
# Banked Address Filter with Per-Bank Search Mask

This block sits beside a memory-ordering queue that is physically split into several banks. Each queue bank is paired with a private array of small saturating counters. These counters record, in hashed form, the addresses of the operations currently held in that bank. When a memory operation executes, its address is folded into a short index once. That index reads every bank's array at the same time. The result is a mask with one bit per queue bank: a set bit means that bank may hold a matching address and has to be searched associatively. An all-zero mask means no queue bank needs a search.

When an operation is placed into a queue bank, its address is counted only in the array that belongs to that bank. When the operation commits, the owner sends back the bank number and the folded index, and only that one counter is decremented. A global clear input empties every array, for example after a pipeline flush. Alongside the mask, the block reports how many bits of the mask are set.

The bank count is 4, 8 or 16. The per-bank array depth is 128, 64 or 32 to match, so the total stays at 512 counters.

Top module: `bank_filter_mask`

## Requirements
- R1: After reset is released, every counter is zero, `mask_valid_o` is 0, `mask_o` is all zero and `mask_cnt_o` is 0.
- R2: The folded index has IDX_W = log2(512/NUM_BANKS) bits. Index bit k is the XOR of every address bit whose position modulo IDX_W equals k. Two addresses with the same index are treated as the same address.
- R3: An insert with bank number b increments only the counter at the folded index of `ins_addr_i` in bank b. A later probe sets mask bit b only, unless other banks already hold that index.
- R4: A probe reads all banks in parallel. Mask bit b is 1 exactly when bank b's counter at the probe index is nonzero.
- R5: The mask appears registered, one cycle after `probe_valid_i`, with `mask_valid_o` high. In a cycle after no probe, `mask_valid_o` is 0 and `mask_o` is zero.
- R6: Whenever `mask_valid_o` is high, `mask_cnt_o` equals the number of ones in `mask_o`.
- R7: A remove with bank number and index decrements only that counter. A counter raised by n inserts clears its mask bit only after n removes.
- R8: A counter stops at 2^CNT_W-1. Once it is there, further inserts and removes leave it unchanged until a clear.
- R9: An insert and a remove that hit the same counter in the same cycle leave it unchanged. A remove on a zero counter leaves it at zero.
- R10: `clear_i` zeroes every counter in every bank and takes priority over an insert or remove in the same cycle.
- R11: A probe sees the counters as they were before the clock edge that samples it. An insert in the same cycle is not visible to that probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Zero all counters in all banks |
| probe_valid_i | input | 1 | Probe request |
| probe_addr_i | input | ADDR_W | Address to probe |
| ins_valid_i | input | 1 | Insert request |
| ins_bank_i | input | BANK_W | Queue bank receiving the operation |
| ins_addr_i | input | ADDR_W | Address of the inserted operation |
| rem_valid_i | input | 1 | Remove request at commit |
| rem_bank_i | input | BANK_W | Bank of the committing operation |
| rem_idx_i | input | IDX_W | Folded index of the committing operation |
| mask_valid_o | output | 1 | Mask is valid this cycle |
| mask_o | output | NUM_BANKS | Banks that must be searched |
| mask_cnt_o | output | CNT_OUT_W | Number of set bits in the mask |

## Verification
The bench targets the following corner cases. For each one, it names the symptom that a faulty design would show:

- **Index aliasing.** A different address with the same folded index must hit. A wrong fold misses it.
- **Single-bank insert.** An insert must land in one bank only. A broken bank decode would light the wrong bits, or several bits.
- **Saturation.** A counter driven past its limit must stay pinned there through removes. A wrapping counter would instead report the bank empty.
- **Coincident insert and remove.** When both hit one counter in the same cycle, the counter must not change. A design that lets one of them win would leave a stale bit, or lose one.
- **Remove on an empty counter.** It must do nothing. An underflowing design would wrap to the limit and keep the bank lit forever.
- **Clear with a same-cycle insert.** The clear must win. A design that lets the insert through would keep a bit set after the clear.
- **Probe with a same-cycle insert.** The probe must not see the insert. A design that forwards it would report a hit too early.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD,
    CNT_INC,
    CNT_DEC,
    CNT_ZERO
  } cnt_act_e;

  // clear wins; a pinned counter ignores traffic; inc+dec cancel; no underflow
  function automatic cnt_act_e cnt_action(input logic clr, input logic inc,
                                          input logic dec, input logic sat,
                                          input logic empty);
    if (clr) return CNT_ZERO;
    if (sat) return CNT_HOLD;
    if (inc && !dec) return CNT_INC;
    if (dec && !inc && !empty) return CNT_DEC;
    return CNT_HOLD;
  endfunction
endpackage

// File: rtl/bfm_hash.sv
module bfm_hash #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ADDR_W; i++) idx_o[i % IDX_W] ^= addr_i[i];
  end
endmodule

// File: rtl/bfm_popcnt.sv
module bfm_popcnt #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 3
) (
  input  logic [IN_W-1:0]  vec_i,
  output logic [OUT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < IN_W; i++) cnt_o += OUT_W'(vec_i[i]);
  end
endmodule

// File: rtl/bfm_bank.sv
module bfm_bank
  import bfm_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int IDX_W   = 7,
  parameter int CNT_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic [IDX_W-1:0] inc_idx_i,
  input  logic             dec_i,
  input  logic [IDX_W-1:0] dec_idx_i,
  input  logic [IDX_W-1:0] probe_idx_i,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ENTRIES-1:0] nz;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [CNT_W-1:0] cnt_q;
    cnt_act_e         act;

    assign act = cnt_action(clear_i,
                            inc_i && (inc_idx_i == IDX_W'(e)),
                            dec_i && (dec_idx_i == IDX_W'(e)),
                            cnt_q == CNT_MAX,
                            cnt_q == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else begin
        unique case (act)
          CNT_ZERO: cnt_q <= '0;
          CNT_INC:  cnt_q <= cnt_q + 1'b1;
          CNT_DEC:  cnt_q <= cnt_q - 1'b1;
          default:  cnt_q <= cnt_q;
        endcase
      end
    end

    assign nz[e] = |cnt_q;
  end

  assign hit_o = nz[probe_idx_i];
endmodule

// File: rtl/bank_filter_mask.sv
module bank_filter_mask #(
  parameter int NUM_BANKS     = 4,
  parameter int TOTAL_ENTRIES = 512,
  parameter int ADDR_W        = 32,
  parameter int CNT_W         = 3,
  localparam int ENTRIES      = TOTAL_ENTRIES / NUM_BANKS,
  localparam int IDX_W        = $clog2(ENTRIES),
  localparam int BANK_W       = $clog2(NUM_BANKS),
  localparam int CNT_OUT_W    = $clog2(NUM_BANKS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 probe_valid_i,
  input  logic [ADDR_W-1:0]    probe_addr_i,
  input  logic                 ins_valid_i,
  input  logic [BANK_W-1:0]    ins_bank_i,
  input  logic [ADDR_W-1:0]    ins_addr_i,
  input  logic                 rem_valid_i,
  input  logic [BANK_W-1:0]    rem_bank_i,
  input  logic [IDX_W-1:0]     rem_idx_i,
  output logic                 mask_valid_o,
  output logic [NUM_BANKS-1:0] mask_o,
  output logic [CNT_OUT_W-1:0] mask_cnt_o
);
  if (!(NUM_BANKS == 4 || NUM_BANKS == 8 || NUM_BANKS == 16)) begin : g_bad_cfg
    $error("bank_filter_mask: NUM_BANKS must be 4, 8 or 16");
  end

  logic [IDX_W-1:0]     probe_idx, ins_idx;
  logic [NUM_BANKS-1:0] hits;
  logic [CNT_OUT_W-1:0] hit_cnt;

  bfm_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_probe (
    .addr_i(probe_addr_i), .idx_o(probe_idx)
  );
  bfm_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_ins (
    .addr_i(ins_addr_i), .idx_o(ins_idx)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bfm_bank #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (clear_i),
      .inc_i      (ins_valid_i && (ins_bank_i == BANK_W'(b))),
      .inc_idx_i  (ins_idx),
      .dec_i      (rem_valid_i && (rem_bank_i == BANK_W'(b))),
      .dec_idx_i  (rem_idx_i),
      .probe_idx_i(probe_idx),
      .hit_o      (hits[b])
    );
  end

  bfm_popcnt #(.IN_W(NUM_BANKS), .OUT_W(CNT_OUT_W)) u_popcnt (
    .vec_i(hits), .cnt_o(hit_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_valid_o <= 1'b0;
      mask_o       <= '0;
      mask_cnt_o   <= '0;
    end else begin
      mask_valid_o <= probe_valid_i;
      mask_o       <= probe_valid_i ? hits : '0;
      mask_cnt_o   <= probe_valid_i ? hit_cnt : '0;
    end
  end
endmodule

// File: rtl/bank_filter_mask_chk.sv
module bank_filter_mask_chk #(
  parameter int NUM_BANKS = 4,
  parameter int CNT_OUT_W = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 clear_i,
  input logic                 probe_valid_i,
  input logic                 mask_valid_o,
  input logic [NUM_BANKS-1:0] mask_o,
  input logic [CNT_OUT_W-1:0] mask_cnt_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_valid_i |=> mask_valid_o);  // R5

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_valid_o |-> (mask_o == '0));  // R5

  AST_COUNT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_valid_o |-> (32'(mask_cnt_o) == $countones(mask_o)));  // R6

  AST_CLEAR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i ##1 probe_valid_i |=> (mask_o == '0));  // R10
endmodule

bind bank_filter_mask bank_filter_mask_chk #(
  .NUM_BANKS(NUM_BANKS), .CNT_OUT_W(CNT_OUT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clear_i      (clear_i),
  .probe_valid_i(probe_valid_i),
  .mask_valid_o (mask_valid_o),
  .mask_o       (mask_o),
  .mask_cnt_o   (mask_cnt_o)
);

// File: tb/bank_filter_mask_test.sv
module bank_filter_mask_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB    = 4;
  localparam int AW    = 32;
  localparam int IW    = 7;
  localparam int BW    = 2;
  localparam int CW    = 3;
  localparam int LIMIT = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear = 1'b0;
  logic          p_v = 1'b0;
  logic [AW-1:0] p_a = '0;
  logic          i_v = 1'b0;
  logic [BW-1:0] i_b = '0;
  logic [AW-1:0] i_a = '0;
  logic          r_v = 1'b0;
  logic [BW-1:0] r_b = '0;
  logic [IW-1:0] r_i = '0;
  logic          m_v;
  logic [NB-1:0] m;
  logic [CW-1:0] m_c;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_filter_mask #(.NUM_BANKS(NB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
    .probe_valid_i(p_v), .probe_addr_i(p_a),
    .ins_valid_i(i_v), .ins_bank_i(i_b), .ins_addr_i(i_a),
    .rem_valid_i(r_v), .rem_bank_i(r_b), .rem_idx_i(r_i),
    .mask_valid_o(m_v), .mask_o(m), .mask_cnt_o(m_c)
  );

  // fold per R2
  function automatic logic [IW-1:0] fold(input logic [AW-1:0] a);
    logic [IW-1:0] h = '0;
    for (int i = 0; i < AW; i++) h[i % IW] ^= a[i];
    return h;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ins(input int b, input logic [AW-1:0] a);
    i_v = 1'b1; i_b = BW'(b); i_a = a;
    step();
    i_v = 1'b0;
  endtask

  task automatic rem(input int b, input logic [AW-1:0] a);
    r_v = 1'b1; r_b = BW'(b); r_i = fold(a);
    step();
    r_v = 1'b0;
  endtask

  task automatic probe(input string req, input logic [AW-1:0] a, input logic [NB-1:0] exp);
    p_v = 1'b1; p_a = a;
    step();
    p_v = 1'b0;
    expect_eq({req, " mask"}, int'(m), int'(exp));
    expect_eq("R6 popcount", int'(m_c), $countones(exp));
    expect_eq("R5 valid", int'(m_v), 1);
  endtask

  localparam logic [AW-1:0] ADDR_A = 32'h0000_0011;  // index 0x11
  localparam logic [AW-1:0] ADDR_B = 32'h0000_0080;  // index 0x01
  localparam logic [AW-1:0] ADDR_X = 32'h0000_0001;  // aliases ADDR_B
  localparam logic [AW-1:0] ADDR_C = 32'h0000_0022;  // index 0x22

  // {op[1:0] (0 probe,1 insert,2 remove), bank[1:0], addr[31:0], exp_mask[3:0]}
  localparam int NVEC = 12;
  localparam logic [39:0] VEC [NVEC] = '{
    {2'd1, 2'd0, ADDR_A, 4'b0000},
    {2'd0, 2'd0, ADDR_A, 4'b0001},  // R3
    {2'd1, 2'd2, ADDR_A, 4'b0000},
    {2'd0, 2'd0, ADDR_A, 4'b0101},  // R4
    {2'd0, 2'd0, ADDR_C, 4'b0000},  // R4
    {2'd1, 2'd3, ADDR_B, 4'b0000},
    {2'd0, 2'd0, ADDR_X, 4'b1000},  // R2 alias
    {2'd2, 2'd0, ADDR_A, 4'b0000},
    {2'd0, 2'd0, ADDR_A, 4'b0100},  // R7
    {2'd2, 2'd2, ADDR_A, 4'b0000},
    {2'd0, 2'd0, ADDR_A, 4'b0000},  // R7
    {2'd0, 2'd0, ADDR_B, 4'b1000}   // R3
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_eq("R1 valid", int'(m_v), 0);
    expect_eq("R1 mask", int'(m), 0);
    expect_eq("R1 count", int'(m_c), 0);
    probe("R1 empty", ADDR_A, 4'b0000);

    for (int v = 0; v < NVEC; v++) begin
      case (VEC[v][39:38])
        2'd1: ins(int'(VEC[v][37:36]), VEC[v][35:4]);
        2'd2: rem(int'(VEC[v][37:36]), VEC[v][35:4]);
        default: probe("R3/R4 table", VEC[v][35:4], VEC[v][3:0]);
      endcase
    end
    rem(3, ADDR_B);

    // R5: idle cycle clears valid and mask
    step();
    expect_eq("R5 idle valid", int'(m_v), 0);
    expect_eq("R5 idle mask", int'(m), 0);

    // R11: same-cycle insert invisible to probe
    i_v = 1'b1; i_b = 2'd1; i_a = ADDR_C; p_v = 1'b1; p_a = ADDR_C;
    step();
    i_v = 1'b0; p_v = 1'b0;
    expect_eq("R11 same-cycle", int'(m), 0);
    probe("R11 next", ADDR_C, 4'b0010);

    // R8: saturate bank1 then remove more than inserted
    for (int k = 0; k < LIMIT; k++) ins(1, ADDR_C);
    for (int k = 0; k < LIMIT + 1; k++) rem(1, ADDR_C);
    probe("R8 pinned", ADDR_C, 4'b0010);

    // R9: coincident insert and remove on bank0 counter at zero
    i_v = 1'b1; i_b = 2'd0; i_a = ADDR_C;
    r_v = 1'b1; r_b = 2'd0; r_i = fold(ADDR_C);
    step();
    i_v = 1'b0; r_v = 1'b0;
    probe("R9 cancel", ADDR_C, 4'b0010);
    rem(0, ADDR_C);
    ins(0, ADDR_C);
    probe("R9 no underflow", ADDR_C, 4'b0011);
    rem(0, ADDR_C);
    probe("R9 back to zero", ADDR_C, 4'b0010);

    // R7: two inserts need two removes
    ins(3, ADDR_A);
    ins(3, ADDR_A);
    rem(3, ADDR_A);
    probe("R7 one left", ADDR_A, 4'b1000);
    rem(3, ADDR_A);
    probe("R7 none left", ADDR_A, 4'b0000);

    // R10: clear beats same-cycle insert, empties saturated counter
    clear = 1'b1; i_v = 1'b1; i_b = 2'd2; i_a = ADDR_A;
    step();
    clear = 1'b0; i_v = 1'b0;
    probe("R10 insert dropped", ADDR_A, 4'b0000);
    probe("R10 saturated cleared", ADDR_C, 4'b0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule